// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block gathers up to eight interrupt lines into one interrupt output. Each line is edge-sensitive, so only a rising transition counts as a new request. A request that is not masked is held in a pending register. When a request is accepted and no line of equal or higher rank is being serviced, the block raises a single-cycle pulse on its interrupt output.

The processor side answers the pulse with an acknowledge strobe. The block then takes the highest-numbered pending line and returns an 8-bit vector for it. In normal mode it marks that line as in service. Service ends when a separate command decoder sends an end-of-interrupt (EOI) strobe. That strobe either names a line or clears the highest-ranked line in service. After each EOI the block looks again at the pending requests, so a request that was held back can now be signalled. When a downstream responder is attached, it can provide the vector for lines that are flagged as cascaded. A read-back byte shows either the pending register or the in-service register.

Top module: `irq_prio_core`

## Requirements
- R1: A request is recorded only on a low-to-high change of a pin. A pin held high records nothing more after its first edge.
- R2: An edge on a line whose bit in `mask_val` is 1 is discarded. Clearing the mask afterwards does not bring that request back.
- R3: An accepted request sets its pending bit. `irq_pulse` rises on the next clock only if no in-service bit at that line number or above is set.
- R4: On `ack` the highest-numbered pending bit is chosen, and that bit is cleared from the pending register.
- R5: With `auto_eoi` = 1 an acknowledged line is never marked in service. With `auto_eoi` = 0 its in-service bit is set.
- R6: The vector after an acknowledge is `vec_base[7:3]` in bits 7:3 and the line number in bits 2:0. It appears on `vector` one clock after `ack`.
- R7: `eoi_any` clears the highest-numbered in-service bit. `eoi_one` clears the in-service bit selected by `eoi_line`.
- R8: After any EOI, including the implicit one of an auto-EOI acknowledge, `irq_pulse` is raised if pending requests remain and no in-service bit at or above the highest pending line is set.
- R9: When `resp_present` = 1 and the `cascade_bits` bit of the acknowledged line is 1, `vector` takes `resp_vector` instead of the local value.
- R10: `readback` shows the pending register when the select flag is 1 and the in-service register when it is 0. The flag is written with `rdsel_we`/`rdsel_val` and resets to 1.
- R11: An acknowledge with nothing pending returns `{vec_base[7:3], 3'b111}` and leaves both registers unchanged.
- R12: Reset clears the pending, in-service and mask-independent state and `irq_pulse`. Each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pins | input | 8 | Interrupt pin levels |
| mask_val | input | 8 | Per-line mask, 1 drops edges |
| ack | input | 1 | Acknowledge strobe |
| eoi_any | input | 1 | Non-specific EOI strobe |
| eoi_one | input | 1 | Specific EOI strobe |
| eoi_line | input | 3 | Line cleared by specific EOI |
| vec_base | input | 8 | Vector base, low 3 bits ignored |
| auto_eoi | input | 1 | Auto-EOI mode |
| rdsel_we | input | 1 | Write strobe for read select |
| rdsel_val | input | 1 | New read select (1 pending, 0 in service) |
| cascade_bits | input | 8 | Lines served by a responder |
| resp_present | input | 1 | Responder attached |
| resp_vector | input | 8 | Vector supplied by responder |
| vector | output | 8 | Vector of last acknowledge |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| readback | output | 8 | Pending or in-service register |

## Verification
Single edges, paired simultaneous edges and pins held high show the difference between edge capture and level capture. Requests placed below, above and beside a line already in service show whether the in-service blocking looks at the right range of bits. Non-specific EOI, specific EOI and auto-EOI acknowledges are each followed by checks of whether the output pulses again, so an EOI path that skips the re-evaluation shows up. Acknowledges with nothing pending, with a base that has low bits set, and with and without a cascaded responder separate the vector sources.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt request priority core.
// Assumes: nothing beyond the standard.
package irq_pkg;
    // Encoding of the read-back select flag.
    typedef enum logic {
        RB_INSERVICE = 1'b0,
        RB_PENDING   = 1'b1
    } rb_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
// Per-line rising-edge detector.
// Assumes: pins are already synchronous to clk.
module irq_edge_detect #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pins,
    output logic [LINES-1:0] prev_q,
    output logic [LINES-1:0] rise
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Remember last level of this pin.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= pins[g];
        end
        // Rising transition seen this cycle.
        assign rise[g] = pins[g] & ~prev_q[g];
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Finds the highest-numbered set bit of a vector.
// Assumes: the caller checks 'hit' before using 'idx'.
module irq_prio_enc #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    // Scan upward so the last set bit wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        hit = |vec;
    end
endmodule

// File: rtl/irq_req_state.sv
// Pending and in-service registers, and the interrupt pulse.
// Order inside one cycle: acknowledge, then EOI, then new edges.
// Assumes: ack_line/ack_hit describe the current pending register.
module irq_req_state #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise,
    input  logic [LINES-1:0] mask_val,
    input  logic             ack,
    input  logic             ack_hit,
    input  logic [IDX_W-1:0] ack_line,
    input  logic             auto_eoi,
    input  logic             eoi_any,
    input  logic             eoi_one,
    input  logic [IDX_W-1:0] eoi_line,
    output logic [LINES-1:0] irr_q,
    output logic [LINES-1:0] isr_q,
    output logic             pulse_q
);
    // Index of highest set bit.
    function automatic logic [IDX_W-1:0] top_set(input logic [LINES-1:0] v);
        top_set = '0;
        for (int i = 0; i < LINES; i++) begin
            if (v[i]) top_set = IDX_W'(i);
        end
    endfunction

    // True when no bit at position l or above is set.
    function automatic logic clear_from(input logic [LINES-1:0] v,
                                        input logic [IDX_W-1:0] l);
        clear_from = ((v >> l) == '0);
    endfunction

    logic [LINES-1:0] irr_a, isr_a, isr_n, irr_n, taken;
    logic             eoi_evt, edge_ok, reeval_ok;

    // Next-state computation for both registers and the pulse.
    always_comb begin
        irr_a   = irr_q;
        isr_a   = isr_q;
        eoi_evt = 1'b0;
        if (ack && ack_hit) begin
            irr_a[ack_line] = 1'b0;
            if (auto_eoi) eoi_evt = 1'b1;
            else          isr_a[ack_line] = 1'b1;
        end
        isr_n = isr_a;
        if (eoi_any) begin
            eoi_evt = 1'b1;
            if (isr_a != '0) isr_n[top_set(isr_a)] = 1'b0;
        end
        if (eoi_one) begin
            eoi_evt = 1'b1;
            isr_n[eoi_line] = 1'b0;
        end
        taken   = rise & ~mask_val;
        irr_n   = irr_a | taken;
        edge_ok = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (taken[i] && clear_from(isr_n, IDX_W'(i))) edge_ok = 1'b1;
        end
        reeval_ok = eoi_evt && (irr_n != '0) && clear_from(isr_n, top_set(irr_n));
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q   <= '0;
            isr_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            irr_q   <= irr_n;
            isr_q   <= isr_n;
            pulse_q <= edge_ok | reeval_ok;
        end
    end
endmodule

// File: rtl/irq_vector_out.sv
// Registers the vector returned for each acknowledge.
// Assumes: LINES is a power of two no wider than VEC_W allows.
module irq_vector_out #(
    parameter int LINES = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             ack_hit,
    input  logic [IDX_W-1:0] ack_line,
    input  logic [VEC_W-1:0] vec_base,
    input  logic [LINES-1:0] cascade_bits,
    input  logic             resp_present,
    input  logic [VEC_W-1:0] resp_vector,
    output logic [VEC_W-1:0] vector_q
);
    logic [VEC_W-1:0] base_hi, vec_d;

    // Select the vector source for this acknowledge.
    always_comb begin
        base_hi = {vec_base[VEC_W-1:IDX_W], IDX_W'(0)};
        if (!ack_hit)
            vec_d = base_hi | VEC_W'(LINES - 1);
        else if (resp_present && cascade_bits[ack_line])
            vec_d = resp_vector;
        else
            vec_d = base_hi | VEC_W'(ack_line);
    end

    // Hold the vector until the next acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   vector_q <= '0;
        else if (ack) vector_q <= vec_d;
    end
endmodule

// File: rtl/irq_prio_core.sv
// Top of the interrupt request priority core.
// Assumes: all inputs are synchronous to clk; strobes are one cycle wide.
module irq_prio_core
    import irq_pkg::*;
#(
    parameter int LINES = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_pins,
    input  logic [LINES-1:0] mask_val,
    input  logic             ack,
    input  logic             eoi_any,
    input  logic             eoi_one,
    input  logic [IDX_W-1:0] eoi_line,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             auto_eoi,
    input  logic             rdsel_we,
    input  logic             rdsel_val,
    input  logic [LINES-1:0] cascade_bits,
    input  logic             resp_present,
    input  logic [VEC_W-1:0] resp_vector,
    output logic [VEC_W-1:0] vector,
    output logic             irq_pulse,
    output logic [LINES-1:0] readback
);
    logic [LINES-1:0] pin_prev, rise, irr_q, isr_q;
    logic [IDX_W-1:0] ack_line;
    logic             ack_hit;
    rb_sel_e          rb_sel_q;

    irq_edge_detect #(.LINES(LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pins(irq_pins),
        .prev_q(pin_prev), .rise(rise)
    );

    irq_prio_enc #(.LINES(LINES)) u_enc (
        .vec(irr_q), .idx(ack_line), .hit(ack_hit)
    );

    irq_req_state #(.LINES(LINES)) u_state (
        .clk(clk), .rst_n(rst_n), .rise(rise), .mask_val(mask_val),
        .ack(ack), .ack_hit(ack_hit), .ack_line(ack_line),
        .auto_eoi(auto_eoi), .eoi_any(eoi_any), .eoi_one(eoi_one),
        .eoi_line(eoi_line), .irr_q(irr_q), .isr_q(isr_q), .pulse_q(irq_pulse)
    );

    irq_vector_out #(.LINES(LINES), .VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst_n(rst_n), .ack(ack), .ack_hit(ack_hit),
        .ack_line(ack_line), .vec_base(vec_base), .cascade_bits(cascade_bits),
        .resp_present(resp_present), .resp_vector(resp_vector), .vector_q(vector)
    );

    // Read-back select flag, resets to the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n)        rb_sel_q <= RB_PENDING;
        else if (rdsel_we) rb_sel_q <= rb_sel_e'(rdsel_val);
    end

    // Read-back multiplexer.
    assign readback = (rb_sel_q == RB_PENDING) ? irr_q : isr_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
// Property checker for irq_prio_core, bound to every instance.
module irq_prio_core_chk #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_pins,
    input logic [LINES-1:0] pin_prev,
    input logic [LINES-1:0] mask_val,
    input logic             ack,
    input logic             auto_eoi,
    input logic             eoi_any,
    input logic             eoi_one,
    input logic [IDX_W-1:0] eoi_line,
    input logic [LINES-1:0] irr_q,
    input logic [LINES-1:0] isr_q,
    input logic             irq_pulse
);
    assert_new_pending_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irr_q & ~$past(irr_q) & ~$past(irq_pins & ~pin_prev)) == '0));

    assert_masked_not_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irr_q & ~$past(irr_q) & $past(mask_val)) == '0));

    assert_pulse_has_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (irr_q != '0));

    assert_auto_keeps_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && irr_q != '0 && !eoi_any && !eoi_one) |=> (isr_q == $past(isr_q)));

    assert_specific_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_one && !ack) |=> !isr_q[$past(eoi_line)]);

    assert_empty_ack_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irr_q == '0 && !eoi_any && !eoi_one) |=> $stable(isr_q));
endmodule

bind irq_prio_core irq_prio_core_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .pin_prev(pin_prev),
    .mask_val(mask_val), .ack(ack), .auto_eoi(auto_eoi), .eoi_any(eoi_any),
    .eoi_one(eoi_one), .eoi_line(eoi_line), .irr_q(irr_q), .isr_q(isr_q),
    .irq_pulse(irq_pulse)
);

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pins = '0, mask_val = '0, vec_base = 8'h20;
    logic       ack = 1'b0, eoi_any = 1'b0, eoi_one = 1'b0;
    logic [2:0] eoi_line = '0;
    logic       auto_eoi = 1'b0, rdsel_we = 1'b0, rdsel_val = 1'b1;
    logic [7:0] cascade_bits = '0, resp_vector = '0;
    logic       resp_present = 1'b0;
    logic [7:0] vector, readback;
    logic       irq_pulse;

    int checks = 0, errors = 0;
    bit done = 0;
    logic       ack_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    irq_prio_core u0 (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .mask_val(mask_val),
        .ack(ack), .eoi_any(eoi_any), .eoi_one(eoi_one), .eoi_line(eoi_line),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .rdsel_we(rdsel_we),
        .rdsel_val(rdsel_val), .cascade_bits(cascade_bits),
        .resp_present(resp_present), .resp_vector(resp_vector),
        .vector(vector), .irq_pulse(irq_pulse), .readback(readback)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Driver: push expected vector, strobe acknowledge for one cycle.
    task automatic do_ack(logic [7:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic set_rdsel(logic v);
        rdsel_we = 1'b1; rdsel_val = v;
        tick();
        rdsel_we = 1'b0;
    endtask

    // Monitor: note acknowledges seen by the design.
    always @(posedge clk) ack_d <= ack;

    // Monitor: compare the vector one clock after each acknowledge.
    always @(negedge clk) begin
        if (ack_d && exp_q.size() > 0) begin
            check(tag_q.pop_front(), vector, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R12 reset readback", readback, 8'h00);
        check("R12 reset pulse", {7'd0, irq_pulse}, 8'h00);
        check("R12 reset vector", vector, 8'h00);

        // Single edge on line 3
        irq_pins[3] = 1'b1; tick();
        check("R3 pulse on edge", {7'd0, irq_pulse}, 8'h01);
        check("R1 pending after edge", readback, 8'h08);
        tick();
        check("R12 pulse one clock", {7'd0, irq_pulse}, 8'h00);
        tick();
        check("R1 held pin", readback, 8'h08);

        do_ack(8'h23, "R4 R6 vector line 3");
        check("R4 pending cleared", readback, 8'h00);
        tick(); tick();
        check("R1 no re-request while high", readback, 8'h00);
        check("R1 no pulse while high", {7'd0, irq_pulse}, 8'h00);

        // Line 1 below in-service line 3
        irq_pins[1] = 1'b1; tick();
        check("R3 blocked below service", {7'd0, irq_pulse}, 8'h00);
        check("R3 pending set", readback, 8'h02);
        // Line 5 above
        irq_pins[5] = 1'b1; tick();
        check("R3 pulse above service", {7'd0, irq_pulse}, 8'h01);
        check("R3 pending two", readback, 8'h22);

        do_ack(8'h25, "R4 highest line 5");
        check("R4 pending after ack", readback, 8'h02);
        set_rdsel(1'b0);
        check("R10 R5 in-service view", readback, 8'h28);

        eoi_any = 1'b1; tick(); eoi_any = 1'b0;
        check("R7 non-specific clears top", readback, 8'h08);
        check("R8 still blocked", {7'd0, irq_pulse}, 8'h00);

        eoi_one = 1'b1; eoi_line = 3'd3; tick(); eoi_one = 1'b0;
        check("R7 specific clears line 3", readback, 8'h00);
        check("R8 re-evaluate pulse", {7'd0, irq_pulse}, 8'h01);

        do_ack(8'h21, "R6 vector line 1");
        check("R5 in service line 1", readback, 8'h02);
        eoi_one = 1'b1; eoi_line = 3'd1; tick(); eoi_one = 1'b0;
        check("R7 specific clears line 1", readback, 8'h00);
        check("R8 no pulse when empty", {7'd0, irq_pulse}, 8'h00);

        // Masking
        irq_pins = '0; tick(); tick();
        mask_val = 8'h40;
        irq_pins[6] = 1'b1; tick();
        check("R2 masked no pulse", {7'd0, irq_pulse}, 8'h00);
        set_rdsel(1'b1);
        check("R2 masked not pending", readback, 8'h00);
        mask_val = 8'h00; tick(); tick();
        check("R2 unmask brings nothing", readback, 8'h00);
        check("R2 unmask no pulse", {7'd0, irq_pulse}, 8'h00);

        // Empty acknowledge with base low bits set
        irq_pins = '0; tick();
        vec_base = 8'h4D;
        do_ack(8'h4F, "R11 R6 empty acknowledge");
        check("R11 pending unchanged", readback, 8'h00);
        set_rdsel(1'b0);
        check("R11 in service unchanged", readback, 8'h00);

        // Auto-EOI with two simultaneous edges
        auto_eoi = 1'b1;
        irq_pins[2] = 1'b1; irq_pins[4] = 1'b1; tick();
        check("R3 pulse on pair", {7'd0, irq_pulse}, 8'h01);
        set_rdsel(1'b1);
        check("R1 pair pending", readback, 8'h14);
        do_ack(8'h4C, "R6 auto line 4");
        check("R8 auto-EOI re-evaluate", {7'd0, irq_pulse}, 8'h01);
        check("R4 pending after auto ack", readback, 8'h04);
        set_rdsel(1'b0);
        check("R5 auto no service", readback, 8'h00);

        // Cascade
        resp_present = 1'b1; cascade_bits = 8'h04; resp_vector = 8'h91;
        do_ack(8'h91, "R9 responder vector");
        irq_pins[0] = 1'b1; tick();
        do_ack(8'h48, "R9 local line 0 not cascaded");
        irq_pins[2] = 1'b0; tick();
        irq_pins[2] = 1'b1; resp_present = 1'b0; tick();
        do_ack(8'h4A, "R9 no responder local vector");
        tick();
        finish_run();
    end
endmodule